// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the array address for a four-beat memory burst. When an address strobe has been accepted, the upstream decode raises a load pulse. The block then captures three things: the upper address bits, the two starting low bits and the order mode. The registered output presents the starting address on the next clock. After that, each cycle in which the active-low advance input is low moves the low two bits to the next beat. Each cycle in which advance is high holds the current address, which suspends the burst.

Two beat orders are available, and the order is sampled at load time. The interleaved order visits the start bits XOR the beat index. The linear order visits the start plus the beat index, modulo four. The beat index wraps after the fourth beat, so a held-low advance input cycles through the same four addresses again. Decoding of strobes and chip enables happens upstream and is not part of this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, addr_o is all zeros and the beat index is cleared.
- R2: A cycle with load_i high places {upper_i, start_i} on addr_o after that clock edge, whatever the value of adv_ni in that cycle.
- R3: With order mode 1 (interleaved) latched at load, beat k of the burst drives addr_o[1:0] = start XOR k.
- R4: With order mode 0 (linear) latched at load, beat k of the burst drives addr_o[1:0] = (start + k) mod 4.
- R5: A cycle with load_i low and adv_ni low advances addr_o[1:0] to the next beat of the latched order after that edge.
- R6: A cycle with load_i low and adv_ni high leaves addr_o unchanged.
- R7: The beat index wraps from 3 to 0, so four advances return addr_o[1:0] to the start bits and further advances repeat the same sequence.
- R8: mode_i is sampled only in load cycles. A change of mode_i during a burst does not alter the order until the next load.
- R9: The upper field addr_o[ADDR_W-1:2] changes only after a load cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Accepted-strobe pulse; starts a burst |
| adv_ni | input | 1 | Advance, active low; high suspends |
| mode_i | input | 1 | Beat order: 1 interleaved, 0 linear |
| start_i | input | 2 | Starting low address bits |
| upper_i | input | UPPER_W | Upper address bits captured at load |
| addr_o | output | UPPER_W+2 | Registered array address |

## Verification
Every result of this block appears exactly one clock edge after the cycle that causes it. A load shows its start address once the edge that samples load_i has passed, and each advance or hold likewise shows its effect one edge later. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and then compares at the following falling edge. It checks each beat of both orders for all four starting values. Suspend, wrap-around, mode changes in the middle of a burst and the ignoring of advance during load are each checked against expectations computed from the stated formulas.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned W = BEAT_W
) (
  input  order_e         order_i,
  input  logic [W-1:0]   base_i,
  input  logic [W-1:0]   beat_i,
  output logic [W-1:0]   addr_o
);
  logic [W-1:0] xor_addr;
  logic [W-1:0] lin_addr;

  assign xor_addr = base_i ^ beat_i;
  assign lin_addr = base_i + beat_i;  // wraps modulo 2**W

  always_comb begin
    unique case (order_i)
      ORDER_XOR:    addr_o = xor_addr;
      default:      addr_o = lin_addr;
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int unsigned W = BEAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         mode_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] beat_o,
  output logic [W-1:0] beat_nxt_o,
  output logic [W-1:0] base_o,
  output order_e       order_o
);
  logic [W-1:0] beat_q;
  logic [W-1:0] base_q;
  order_e       order_q;

  assign beat_nxt_o = beat_q + W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= '0;
      base_q  <= '0;
      order_q <= ORDER_LINEAR;
    end else if (load_i) begin
      beat_q  <= '0;
      base_q  <= start_i;
      order_q <= order_e'(mode_i);
    end else if (step_i) begin
      beat_q  <= beat_nxt_o;
    end
  end

  assign beat_o  = beat_q;
  assign base_o  = base_q;
  assign order_o = order_q;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned UPPER_W = 15,
  localparam int unsigned ADDR_W = UPPER_W + BEAT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               adv_ni,
  input  logic               mode_i,
  input  logic [BEAT_W-1:0]  start_i,
  input  logic [UPPER_W-1:0] upper_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic              step;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] base_q;
  order_e            order_q;
  logic [BEAT_W-1:0] low_nxt;
  logic [BEAT_W-1:0] low_q;
  logic [UPPER_W-1:0] upper_q;

  // load wins; advance is ignored in a load cycle
  assign step = ~load_i & ~adv_ni;

  burst_beat_ctr #(.W(BEAT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .step_i     (step),
    .mode_i     (mode_i),
    .start_i    (start_i),
    .beat_o     (beat_q),
    .beat_nxt_o (beat_nxt),
    .base_o     (base_q),
    .order_o    (order_q)
  );

  burst_order_map #(.W(BEAT_W)) u_map (
    .order_i (order_q),
    .base_i  (base_q),
    .beat_i  (beat_nxt),
    .addr_o  (low_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= '0;
      upper_q <= '0;
    end else if (load_i) begin
      low_q   <= start_i;
      upper_q <= upper_i;
    end else if (step) begin
      low_q   <= low_nxt;
    end
  end

  assign addr_o = {upper_q, low_q};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int unsigned UPPER_W = 15,
  localparam int unsigned ADDR_W = UPPER_W + BEAT_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               adv_ni,
  input logic               mode_i,
  input logic [BEAT_W-1:0]  start_i,
  input logic [UPPER_W-1:0] upper_i,
  input logic [ADDR_W-1:0]  addr_o,
  input logic [BEAT_W-1:0]  beat_q,
  input order_e             order_q
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_zero_chk: assert (addr_o == '0 && beat_q == '0);
    end
  end

  // R2
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == {$past(upper_i), $past(start_i)});

  // R3
  xor_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && order_q == ORDER_XOR) |=>
      (addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == ($past(beat_q) ^ (beat_q)));

  // R4
  lin_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && order_q == ORDER_LINEAR) |=>
      addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + BEAT_W'(1));

  // R6
  suspend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(addr_o));

  // R8
  mode_sampled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(order_q));

  // R9
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.UPPER_W(UPPER_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .adv_ni  (adv_ni),
  .mode_i  (mode_i),
  .start_i (start_i),
  .upper_i (upper_i),
  .addr_o  (addr_o),
  .beat_q  (beat_q),
  .order_q (order_q)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int unsigned UW = 15;
  localparam int unsigned AW = UW + 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_ni = 1'b1;
  logic          mode_i = 1'b0;
  logic [1:0]    start_i = '0;
  logic [UW-1:0] upper_i = '0;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  burst_addr_seq #(.UPPER_W(UW)) uut (
    .clk_i, .rst_ni, .load_i, .adv_ni, .mode_i, .start_i, .upper_i, .addr_o
  );

  always #2 clk_i = ~clk_i;  // 250 MHz

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  function automatic logic [1:0] beat_addr(input logic m, input logic [1:0] s, input int k);
    logic [1:0] kk = 2'(k);
    return m ? (s ^ kk) : 2'(s + kk);
  endfunction

  // drive one cycle and check one edge later
  task automatic cyc(input logic ld, input logic an, input logic m,
                     input logic [1:0] s, input logic [UW-1:0] u);
    load_i = ld; adv_ni = an; mode_i = m; start_i = s; upper_i = u;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    check("R1 reset", '0);
  endtask

  task automatic t_order(input logic m, input string req);
    for (int s = 0; s < 4; s++) begin
      logic [UW-1:0] u = UW'(16'h1230 + s);
      cyc(1'b1, 1'b1, m, 2'(s), u);
      check("R2 load", {u, 2'(s)});
      for (int k = 1; k < 4; k++) begin
        cyc(1'b0, 1'b0, m, 2'(s), u);
        check(req, {u, beat_addr(m, 2'(s), k)});
      end
    end
  endtask

  task automatic t_suspend();
    logic [UW-1:0] u = UW'(16'h0555);
    cyc(1'b1, 1'b1, 1'b0, 2'b10, u);
    cyc(1'b0, 1'b0, 1'b0, 2'b00, u);
    check("R5 advance", {u, 2'b11});
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 2'b01, ~u);
      check("R6 suspend", {u, 2'b11});
    end
    cyc(1'b0, 1'b0, 1'b0, 2'b00, u);
    check("R6 resume", {u, 2'b00});
  endtask

  task automatic t_load_ignores_adv();
    logic [UW-1:0] u = UW'(16'h2a2a);
    cyc(1'b1, 1'b0, 1'b1, 2'b01, u);
    check("R2 adv ignored on load", {u, 2'b01});
    cyc(1'b0, 1'b0, 1'b1, 2'b01, u);
    check("R3 first step after load", {u, 2'b00});
  endtask

  task automatic t_wrap();
    logic [UW-1:0] u = UW'(16'h0042);
    cyc(1'b1, 1'b1, 1'b1, 2'b11, u);
    for (int k = 1; k < 10; k++) begin
      cyc(1'b0, 1'b0, 1'b1, 2'b00, u);
      check("R7 wrap", {u, beat_addr(1'b1, 2'b11, k)});
    end
  endtask

  task automatic t_mode_change();
    logic [UW-1:0] u = UW'(16'h7001);
    cyc(1'b1, 1'b1, 1'b0, 2'b01, u);
    cyc(1'b0, 1'b0, 1'b1, 2'b01, u);  // mode flips mid-burst
    check("R8 mode held", {u, 2'b10});
    cyc(1'b0, 1'b0, 1'b1, 2'b01, u);
    check("R8 mode held", {u, 2'b11});
    cyc(1'b1, 1'b1, 1'b1, 2'b01, u);
    cyc(1'b0, 1'b0, 1'b0, 2'b01, u);
    check("R8 new mode after load", {u, 2'b00});
  endtask

  task automatic t_upper();
    logic [UW-1:0] u = UW'(16'h3c3c);
    cyc(1'b1, 1'b1, 1'b0, 2'b00, u);
    cyc(1'b0, 1'b0, 1'b0, 2'b00, ~u);
    check("R9 upper held", {u, 2'b01});
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_order(1'b1, "R3 interleaved");
    t_order(1'b0, "R4 linear");
    t_suspend();
    t_load_ignores_adv();
    t_wrap();
    t_mode_change();
    t_upper();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule